// File: doc/BRIEF.md
# Speculative Address Signature Unit

This unit follows the memory footprint of one speculative thread. It keeps two fixed-length hashed signatures, one for loads and one for stores. Every word address the thread touches is hashed by several independent hash functions, and the resulting bits are ORed into the signature that matches the access type. The unit never checks dependences while accesses arrive. It checks them lazily, when another thread finishes and broadcasts its store signature.

When the local thread commits, the unit presents its store signature as the single outgoing commit message. When a remote commit signature arrives, the unit intersects it with both local signatures. Any common bit raises a one-cycle squash and clears both signatures. Because different addresses can hash to the same bits, a squash can occur without a real dependence, and that is accepted. In every case the remote signature is also expanded into a bitmask of local cache sets. The mask is a superset of every set that could hold a word named by the signature, and the cache uses it for invalidation.

Accesses, outgoing commits and incoming remote signatures are valid/ready streams. A transfer takes place on a rising edge where valid and ready are both high. `acc_ready` is low while a commit is being presented, while a remote signature is offered, or while `clr_in` is high. `rm_ready` is low while a commit is being presented or while `clr_in` is high. `cm_valid`, once raised, holds with a stable `cm_sig` until `cm_ready` is seen.

Top module: `sas_unit`

## Requirements
- R1: After reset both signatures are empty. `cm_valid`, `squash_o` and `inv_valid` are 0, and `acc_ready` is 1 when no input is active.
- R2: An accepted access with `acc_write`=1 sets, one cycle later, the hashed bits of its address in the store signature, which is visible on `cm_sig`.
- R3: An accepted access with `acc_write`=0 sets its hashed bits only in the load signature. `cm_sig` is unchanged, but a later remote signature that shares one of those bits squashes.
- R4: With default parameters the signature has 2048 bits in 4 banks of 512. The bit set by hash k is k*512+idx_k. idx_0 = {addr[7:2], f}, where f[j] is the XOR of bit j, bit j+3, and so on, of the 26-bit value {addr[31:8], addr[1:0]}. For k≥1, bit (b+5k) mod 9 of idx_k is the XOR of all addr[b] that map there.
- R5: Signatures only accumulate. A new access never clears a bit set earlier.
- R6: With `commit_req` high and no commit pending, `cm_valid` rises on the next cycle unless that same edge squashes. It then holds with a stable `cm_sig` until a cycle with `cm_ready` high.
- R7: If an accepted remote signature shares any bit with the load or store signature, `squash_o` is 1 for the next cycle and both signatures are empty in that cycle. A `commit_req` on that same edge is ignored.
- R8: An accepted remote signature with no common bit leaves both signatures unchanged and gives no squash.
- R9: Every accepted remote signature gives `inv_valid`=1 for one cycle. In that cycle `inv_sets[s]` is the OR of remote bits s*8 to s*8+7, the bank-0 segment that set s maps into.
- R10: `clr_in` high empties both signatures on the next cycle and drops a pending commit.
- R11: `acc_ready` = not(`cm_valid` or `rm_valid` or `clr_in`), and `rm_ready` = not(`cm_valid` or `clr_in`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access can be accepted |
| acc_addr | input | 32 | Word address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| commit_req | input | 1 | Local thread requests commit |
| cm_valid | output | 1 | Commit signature presented |
| cm_ready | input | 1 | Commit signature taken |
| cm_sig | output | 2048 | Store signature |
| rm_valid | input | 1 | Remote commit signature offered |
| rm_ready | output | 1 | Remote signature can be accepted |
| rm_sig | input | 2048 | Remote store signature |
| clr_in | input | 1 | Commit-done / external squash clear |
| squash_o | output | 1 | Violation detected (one cycle) |
| inv_valid | output | 1 | Invalidation mask valid (one cycle) |
| inv_sets | output | 64 | Cache sets to invalidate |

## Verification
The bench aims first at load-only overlap. A design that checked the remote signature against the store signature alone would miss that squash. It then holds `cm_ready` low for several cycles while accesses and a remote signature are offered. A design that let either stream through would change `cm_sig` under a pending commit. It also applies collisions on the clear path: a remote hit and a `commit_req` on the same edge, and `clr_in` together with a pending commit. A design with the wrong priority would leave stale bits behind or present an empty commit. Finally, sparse random remote signatures exercise the set-mask expansion. A segment mapped to the wrong set shows up as a differing `inv_sets` bit.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  // Spread used between successive mixing hashes.
  localparam int unsigned HASH_STRIDE = 5;
endpackage

// File: rtl/sas_hash.sv
module sas_hash #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SET_W    = 6,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned NUM_HASH = 4
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic [NUM_HASH*IDX_W-1:0] idx_flat
);
  localparam int unsigned TF_W   = IDX_W - SET_W;
  localparam int unsigned REST_W = ADDR_W - SET_W;

  logic [REST_W-1:0] rest;
  assign rest = {addr[ADDR_W-1:OFF_W+SET_W], addr[OFF_W-1:0]};

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_fn
    if (k == 0) begin : g_setbank
      // Bank 0 keeps the cache-set field intact so it can be decoded back.
      logic [TF_W-1:0] fold;
      always_comb begin
        fold = '0;
        for (int b = 0; b < REST_W; b++) fold[b % TF_W] ^= rest[b];
      end
      assign idx_flat[0 +: IDX_W] = {addr[OFF_W +: SET_W], fold};
    end else begin : g_mix
      logic [IDX_W-1:0] mix;
      always_comb begin
        mix = '0;
        for (int b = 0; b < ADDR_W; b++)
          mix[(b + sas_pkg::HASH_STRIDE * k) % IDX_W] ^= addr[b];
      end
      assign idx_flat[k*IDX_W +: IDX_W] = mix;
    end
  end
endmodule

// File: rtl/sas_sig_store.sv
module sas_sig_store #(
  parameter int unsigned SIG_W    = 2048,
  parameter int unsigned NUM_HASH = 4,
  parameter int unsigned IDX_W    = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      ins,
  input  logic [NUM_HASH*IDX_W-1:0] idx_flat,
  output logic [SIG_W-1:0]          sig
);
  localparam int unsigned BANK_W = SIG_W / NUM_HASH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (clr) begin
      sig <= '0;
    end else if (ins) begin
      for (int k = 0; k < NUM_HASH; k++)
        sig[k*BANK_W + int'(idx_flat[k*IDX_W +: IDX_W])] <= 1'b1;
    end
  end

  // R10: a clear request leaves an empty signature
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0));

  // R5: without a clear no bit is ever lost
  p_accumulate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sig & $past(sig)) == $past(sig)));
endmodule

// File: rtl/sas_probe.sv
module sas_probe #(
  parameter int unsigned SIG_W    = 2048,
  parameter int unsigned NUM_HASH = 4,
  parameter int unsigned SET_W    = 6
) (
  input  logic [SIG_W-1:0]        rm_sig,
  input  logic [SIG_W-1:0]        rd_sig,
  input  logic [SIG_W-1:0]        wr_sig,
  output logic                    overlap,
  output logic [(1<<SET_W)-1:0]   sets
);
  localparam int unsigned BANK_W = SIG_W / NUM_HASH;
  localparam int unsigned SETS   = 1 << SET_W;
  localparam int unsigned SEG_W  = BANK_W / SETS;

  assign overlap = |(rm_sig & (rd_sig | wr_sig));

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign sets[s] = |rm_sig[s*SEG_W +: SEG_W];
  end
endmodule

// File: rtl/sas_unit.sv
module sas_unit #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SIG_W    = 2048,
  parameter int unsigned NUM_HASH = 4,
  parameter int unsigned SET_W    = 6,
  parameter int unsigned OFF_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  output logic                  acc_ready,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic                  acc_write,
  input  logic                  commit_req,
  output logic                  cm_valid,
  input  logic                  cm_ready,
  output logic [SIG_W-1:0]      cm_sig,
  input  logic                  rm_valid,
  output logic                  rm_ready,
  input  logic [SIG_W-1:0]      rm_sig,
  input  logic                  clr_in,
  output logic                  squash_o,
  output logic                  inv_valid,
  output logic [(1<<SET_W)-1:0] inv_sets
);
  localparam int unsigned BANK_W = SIG_W / NUM_HASH;
  localparam int unsigned IDX_W  = $clog2(BANK_W);
  localparam int unsigned SETS   = 1 << SET_W;

  logic [NUM_HASH*IDX_W-1:0] idx_flat;
  logic [SIG_W-1:0]          rd_sig, wr_sig;
  logic                      take, rm_take, overlap, hit, clr_sig;
  logic [SETS-1:0]           sets_c;
  sas_pkg::acc_kind_e        kind;

  assign kind      = sas_pkg::acc_kind_e'(acc_write);
  assign acc_ready = !(cm_valid || rm_valid || clr_in);
  assign rm_ready  = !(cm_valid || clr_in);
  assign take      = acc_valid && acc_ready;
  assign rm_take   = rm_valid && rm_ready;
  assign hit       = rm_take && overlap;
  assign clr_sig   = clr_in || hit;

  sas_hash #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W),
             .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_hash (
    .addr(acc_addr), .idx_flat(idx_flat));

  sas_sig_store #(.SIG_W(SIG_W), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr_sig),
    .ins(take && kind == sas_pkg::ACC_LOAD), .idx_flat(idx_flat), .sig(rd_sig));

  sas_sig_store #(.SIG_W(SIG_W), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(clr_sig),
    .ins(take && kind == sas_pkg::ACC_STORE), .idx_flat(idx_flat), .sig(wr_sig));

  sas_probe #(.SIG_W(SIG_W), .NUM_HASH(NUM_HASH), .SET_W(SET_W)) u_probe (
    .rm_sig(rm_sig), .rd_sig(rd_sig), .wr_sig(wr_sig),
    .overlap(overlap), .sets(sets_c));

  assign cm_sig = wr_sig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cm_valid  <= 1'b0;
      squash_o  <= 1'b0;
      inv_valid <= 1'b0;
      inv_sets  <= '0;
    end else begin
      squash_o  <= hit;
      inv_valid <= rm_take;
      if (rm_take) inv_sets <= sets_c;
      if (clr_in)                              cm_valid <= 1'b0;
      else if (cm_valid && cm_ready)           cm_valid <= 1'b0;
      else if (commit_req && !cm_valid && !hit) cm_valid <= 1'b1;
    end
  end

  // R6: a presented commit stays up with an unchanged signature
  p_commit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready && !clr_in) |=> (cm_valid && $stable(cm_sig)));

  // R6: no access reaches the store signature while a commit is presented
  p_commit_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !clr_in) |=> $stable(wr_sig));

  // R7: a squash is seen with both signatures already empty
  p_squash_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> (rd_sig == '0 && wr_sig == '0));

  // R9: the invalidation pulse follows an accepted remote signature
  p_inv_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> $past(rm_valid && rm_ready));
endmodule

// File: tb/test_sas_unit.sv
module test_sas_unit;
  localparam int PERIOD = 10;
  localparam int AW = 32, SW = 2048, NH = 4, SETB = 6, BW = 512, IW = 9, SEGW = 8;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, commit_req = 0, cm_ready = 0;
  logic rm_valid = 0, clr_in = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] rm_sig = '0;
  logic acc_ready, cm_valid, rm_ready, squash_o, inv_valid;
  logic [SW-1:0] cm_sig;
  logic [63:0] inv_sets;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  sas_unit i_sas_unit (.*);

  always #(PERIOD/2) clk = ~clk;

  // Reference state
  logic [SW-1:0] m_rd = '0, m_wr = '0;
  logic m_cmv = 0, m_sq = 0, m_iv = 0;
  logic [63:0] m_sets = '0;

  function automatic int idx_of(input logic [AW-1:0] a, input int k);
    int r = 0;
    if (k == 0) begin
      int f = 0, pos = 0;
      for (int b = 0; b < AW; b++) begin
        if (b >= 2 && b < 8) continue;
        if (a[b]) f = f ^ (1 << (pos % 3));
        pos++;
      end
      r = (int'(a[7:2]) << 3) | f;
    end else begin
      for (int j = 0; j < IW; j++) begin
        int par = 0;
        for (int b = 0; b < AW; b++)
          if ((b + 5*k) % IW == j) par ^= int'(a[b]);
        if (par != 0) r |= (1 << j);
      end
    end
    return k*BW + r;
  endfunction

  function automatic logic [SW-1:0] sig_of(input logic [AW-1:0] a);
    logic [SW-1:0] s = '0;
    for (int k = 0; k < NH; k++) s[idx_of(a, k)] = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rd = '0; m_wr = '0; m_cmv = 0; m_sq = 0; m_iv = 0; m_sets = '0;
    end else begin
      logic rdy, rrdy, tk, rtk, ht;
      rdy  = !(m_cmv || rm_valid || clr_in);
      rrdy = !(m_cmv || clr_in);
      tk   = acc_valid && rdy;
      rtk  = rm_valid && rrdy;
      ht   = rtk && ((rm_sig & (m_rd | m_wr)) != '0);
      if (rtk) for (int s = 0; s < 64; s++) m_sets[s] = |rm_sig[s*SEGW +: SEGW];
      m_sq = ht;
      m_iv = rtk;
      if (clr_in) m_cmv = 0;
      else if (m_cmv && cm_ready) m_cmv = 0;
      else if (commit_req && !m_cmv && !ht) m_cmv = 1;
      if (clr_in || ht) begin m_rd = '0; m_wr = '0; end
      else if (tk) begin
        if (acc_write) m_wr |= sig_of(acc_addr);
        else           m_rd |= sig_of(acc_addr);
      end
    end
  end

  task automatic chk1(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk1("R11 acc_ready", acc_ready, !(m_cmv || rm_valid || clr_in));
      chk1("R11 rm_ready", rm_ready, !(m_cmv || clr_in));
      chk1("R6 cm_valid", cm_valid, m_cmv);
      chk1("R7 R8 squash_o", squash_o, m_sq);
      chk1("R9 inv_valid", inv_valid, m_iv);
      vectors++;
      if (cm_sig !== m_wr) begin
        miscompares++;
        $display("FAIL R2 R3 R4 R5 cm_sig actual=%h expected=%h", cm_sig, m_wr);
      end
      if (m_iv) begin
        vectors++;
        if (inv_sets !== m_sets) begin
          miscompares++;
          $display("FAIL R9 inv_sets actual=%h expected=%h", inv_sets, m_sets);
        end
      end
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic access(input logic [AW-1:0] a, input logic w);
    acc_valid = 1; acc_addr = a; acc_write = w; step(); acc_valid = 0;
  endtask

  task automatic remote(input logic [SW-1:0] s);
    rm_valid = 1; rm_sig = s; step(); rm_valid = 0; rm_sig = '0;
  endtask

  initial begin
    #(PERIOD*150000);
    vectors++; miscompares++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [SW-1:0] s;
    repeat (3) step();
    rst_n = 1;
    @(negedge clk); #2;
    // R1: reset state
    chk1("R1 cm_valid", cm_valid, 0);
    chk1("R1 squash_o", squash_o, 0);
    chk1("R1 inv_valid", inv_valid, 0);
    chk1("R1 acc_ready", acc_ready, 1);
    vectors++; if (cm_sig !== '0) begin miscompares++; $display("FAIL R1 cm_sig actual=%h expected=0", cm_sig); end
    step();
    // R2 R4 R5: stores accumulate
    access(32'h0000_0104, 1); access(32'hdead_beef, 1); access(32'h0000_0104, 1);
    // R3: loads
    access(32'h1234_5678, 0); access(32'h0000_0ffc, 0);
    // R6: commit held under back-pressure, accesses and remote stalled
    commit_req = 1; step(); commit_req = 0;
    acc_valid = 1; acc_addr = 32'h5555_aaaa; acc_write = 1;
    rm_valid = 1; rm_sig = sig_of(32'h1234_5678);
    repeat (3) step();
    acc_valid = 0; rm_valid = 0; rm_sig = '0;
    cm_ready = 1; step(); cm_ready = 0; step();
    // R8: non-overlapping remote
    s = '0; for (int k = 0; k < SW; k++) if (!m_rd[k] && !m_wr[k]) begin s[k] = 1; break; end
    remote(s); step();
    // R7: load-only overlap squashes, with same-edge commit_req ignored
    commit_req = 1; remote(sig_of(32'h0000_0ffc)); commit_req = 0; step();
    // R10: clear with pending commit
    access(32'h0abc_0010, 1); commit_req = 1; step(); commit_req = 0;
    clr_in = 1; step(); clr_in = 0; step();
    // R7: store overlap
    access(32'h7777_0040, 1); remote(sig_of(32'h7777_0040)); step();
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      acc_valid = (r < 55); acc_addr = $urandom; acc_write = $urandom_range(0, 1);
      commit_req = (r >= 90 && r < 94);
      cm_ready = $urandom_range(0, 1);
      clr_in = (r == 99);
      rm_valid = (r >= 80 && r < 88);
      rm_sig = '0;
      if (rm_valid) begin
        rm_sig[$urandom_range(0, SW-1)] = 1;
        rm_sig[$urandom_range(0, BW-1)] = 1;
      end
      step();
    end
    acc_valid = 0; commit_req = 0; clr_in = 0; rm_valid = 0; cm_ready = 1;
    repeat (4) step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule